// File: doc/BRIEF.md
# Wake event indication generator

This block converts single-cycle detections from a magic-packet detector and a pattern detector into one wake indication line. A detection is held as pending until the frame that carried it ends. When the frame ends, the pending detection either fires or is dropped. That choice depends on the frame's CRC result and on a CRC-gate setting. A fired event drives the indication in one of two ways. In pulse mode the line is high for 8, 16, 32 or 64 clock cycles. In level mode the line stays high until a clear strobe arrives.

A two-bit sticky status word records which source caused a fired event: bit 0 for magic packet and bit 1 for pattern. The status word is cleared by the same strobe that ends a level-mode indication. All configuration arrives on plain input pins. The enclosing register block drives these pins and returns the clear strobe to 0 after one cycle.

Top module: `wake_ind_gen`

## Requirements
- R1: While reset is active and after reset is released, wake_out is 0 and wake_status is 2'b00 until an event fires.
- R2: In pulse mode (cfg_level_mode=0), a fired event makes wake_out high for exactly 8, 16, 32 or 64 cycles for cfg_pulse_sel values 0, 1, 2 and 3. wake_out rises in the cycle after the clock edge that samples frame_end.
- R3: In level mode (cfg_level_mode=1), wake_out stays high after a fired event until cfg_clear is sampled high. It is low from the following cycle.
- R4: With cfg_crc_gate=1, a frame that ends with crc_ok=0 fires nothing, and the hits pending for that frame are discarded.
- R5: With cfg_crc_gate=0, pending hits fire at frame_end whatever the value of crc_ok.
- R6: With cfg_wake_en=0, hits are not latched and nothing fires.
- R7: magic_hit counts only when cfg_magic_en=1, and pattern_hit counts only when cfg_pattern_en=1. Each fired source sets its own status bit: bit 0 for magic and bit 1 for pattern.
- R8: A hit stays pending until the next frame_end. A hit sampled in the same cycle as frame_end belongs to that frame. A frame_end with nothing pending fires nothing.
- R9: An event that fires while a pulse is running restarts the pulse, so wake_out stays high for the full selected width counted from the new event.
- R10: Status bits are sticky until cfg_clear. When cfg_clear and a firing event are sampled in the same cycle, the event wins. The level stays high and the status holds only the new event's source bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_wake_en | input | 1 | Master wake enable |
| cfg_magic_en | input | 1 | Enable for the magic-packet source |
| cfg_pattern_en | input | 1 | Enable for the pattern source |
| cfg_crc_gate | input | 1 | 1: a bad CRC drops the frame's hits |
| cfg_level_mode | input | 1 | 1: level indication, 0: pulse indication |
| cfg_pulse_sel | input | 2 | Pulse width select (8 shifted left by this value) |
| cfg_clear | input | 1 | One-cycle strobe that clears the level and the status |
| magic_hit | input | 1 | Magic-packet detection pulse |
| pattern_hit | input | 1 | Pattern detection pulse |
| frame_end | input | 1 | End-of-frame pulse |
| crc_ok | input | 1 | CRC result, valid with frame_end |
| wake_out | output | 1 | Wake indication line |
| wake_status | output | 2 | Sticky source record: bit 0 magic, bit 1 pattern |

## Verification
Two pairs of functions can fall in the same cycle. The first pair is the level-mode clear strobe and a new firing event. The second pair is a detection and the frame_end that closes its frame. The bench provokes the first pair by holding cfg_clear high in the same cycle as a frame_end that carries a pending pattern hit. It judges the result by expecting wake_out to stay high and wake_status to read 2'b10. It provokes the second pair by raising magic_hit together with frame_end, and it expects a full pulse plus status bit 0.

// File: rtl/wake_ind_pkg.sv
package wake_ind_pkg;

  localparam int SRC_N       = 2;
  localparam int SRC_MAGIC   = 0;
  localparam int SRC_PATTERN = 1;

  // pulse width in cycles for a given select code
  function automatic int unsigned pulse_cycles(input int unsigned base,
                                               input int unsigned sel);
    return base << sel;
  endfunction

  // counter width able to hold the longest pulse
  function automatic int unsigned pulse_cnt_w(input int unsigned base,
                                              input int unsigned sel_w);
    return $clog2(base << ((1 << sel_w) - 1)) + 1;
  endfunction

endpackage

// File: rtl/wake_event_qual.sv
module wake_event_qual #(
  parameter int SRC_N = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wake_en,
  input  logic             crc_gate,
  input  logic [SRC_N-1:0] src_en,
  input  logic [SRC_N-1:0] hit,
  input  logic             frame_end,
  input  logic             crc_ok,
  output logic             fire,
  output logic [SRC_N-1:0] fire_src
);

  logic [SRC_N-1:0] pend_q;
  logic [SRC_N-1:0] pend_all;
  logic             crc_pass;

  assign crc_pass = crc_ok | ~crc_gate;

  for (genvar i = 0; i < SRC_N; i++) begin : g_src
    logic hit_ok;
    assign hit_ok      = hit[i] & src_en[i] & wake_en;
    assign pend_all[i] = pend_q[i] | hit_ok;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         pend_q[i] <= 1'b0;
      else if (frame_end) pend_q[i] <= 1'b0;
      else                pend_q[i] <= pend_all[i];
    end
  end

  assign fire     = frame_end & wake_en & crc_pass & (|pend_all);
  assign fire_src = fire ? pend_all : '0;

endmodule

// File: rtl/wake_pulse_timer.sv
module wake_pulse_timer
  import wake_ind_pkg::*;
#(
  parameter int BASE_LEN = 8,
  parameter int SEL_W    = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [SEL_W-1:0] sel,
  output logic             active
);

  localparam int CNT_W = pulse_cnt_w(BASE_LEN, SEL_W);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] load_val;

  assign load_val = CNT_W'(pulse_cycles(BASE_LEN, 32'(sel)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt_q <= '0;
    else if (load)          cnt_q <= load_val;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign active = (cnt_q != '0);

endmodule

// File: rtl/wake_ind_gen.sv
module wake_ind_gen
  import wake_ind_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_wake_en,
  input  logic       cfg_magic_en,
  input  logic       cfg_pattern_en,
  input  logic       cfg_crc_gate,
  input  logic       cfg_level_mode,
  input  logic [1:0] cfg_pulse_sel,
  input  logic       cfg_clear,
  input  logic       magic_hit,
  input  logic       pattern_hit,
  input  logic       frame_end,
  input  logic       crc_ok,
  output logic       wake_out,
  output logic [1:0] wake_status
);

  logic [SRC_N-1:0] src_en;
  logic [SRC_N-1:0] hit;
  logic             fire;
  logic [SRC_N-1:0] fire_src;
  logic             pulse_active;
  logic             level_q;
  logic [SRC_N-1:0] status_q;

  assign src_en[SRC_MAGIC]   = cfg_magic_en;
  assign src_en[SRC_PATTERN] = cfg_pattern_en;
  assign hit[SRC_MAGIC]      = magic_hit;
  assign hit[SRC_PATTERN]    = pattern_hit;

  wake_event_qual #(.SRC_N(SRC_N)) u_qual (
    .clk      (clk),
    .rst_n    (rst_n),
    .wake_en  (cfg_wake_en),
    .crc_gate (cfg_crc_gate),
    .src_en   (src_en),
    .hit      (hit),
    .frame_end(frame_end),
    .crc_ok   (crc_ok),
    .fire     (fire),
    .fire_src (fire_src)
  );

  wake_pulse_timer #(.BASE_LEN(8), .SEL_W(2)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (fire & ~cfg_level_mode),
    .sel   (cfg_pulse_sel),
    .active(pulse_active)
  );

  // level hold: a new event has priority over the clear strobe
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      level_q <= 1'b0;
    else if (fire && cfg_level_mode) level_q <= 1'b1;
    else if (cfg_clear)              level_q <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) status_q <= '0;
    else        status_q <= (cfg_clear ? '0 : status_q) | fire_src;
  end

  assign wake_out    = cfg_level_mode ? level_q : pulse_active;
  assign wake_status = status_q;

endmodule

// File: rtl/wake_ind_chk.sv
module wake_ind_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cfg_wake_en,
  input logic       cfg_crc_gate,
  input logic       cfg_level_mode,
  input logic       cfg_clear,
  input logic       frame_end,
  input logic       crc_ok,
  input logic       fire,
  input logic [1:0] fire_src,
  input logic       wake_out,
  input logic [1:0] wake_status
);

  a_r4_crc_gate: assert property (@(posedge clk) disable iff (!rst_n)
    fire |-> (frame_end && (crc_ok || !cfg_crc_gate)));

  a_r6_master_enable: assert property (@(posedge clk) disable iff (!rst_n)
    fire |-> cfg_wake_en);

  a_r9_restart_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !cfg_level_mode) |=> (wake_out || cfg_level_mode));

  a_r3_level_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_level_mode && wake_out && !cfg_clear) |=> (wake_out || !cfg_level_mode));

  a_r10_status_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_clear |=> ((wake_status & $past(wake_status)) == $past(wake_status)));

  a_r10_clear_status: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_clear && !fire) |=> (wake_status == 2'b00));

  a_r7_fire_has_source: assert property (@(posedge clk) disable iff (!rst_n)
    fire |-> (fire_src != 2'b00));

endmodule

bind wake_ind_gen wake_ind_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .cfg_wake_en   (cfg_wake_en),
  .cfg_crc_gate  (cfg_crc_gate),
  .cfg_level_mode(cfg_level_mode),
  .cfg_clear     (cfg_clear),
  .frame_end     (frame_end),
  .crc_ok        (crc_ok),
  .fire          (fire),
  .fire_src      (fire_src),
  .wake_out      (wake_out),
  .wake_status   (wake_status)
);

// File: tb/wake_ind_gen_bench.sv
module wake_ind_gen_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_wake_en = 1'b0, cfg_magic_en = 1'b0, cfg_pattern_en = 1'b0;
  logic       cfg_crc_gate = 1'b1, cfg_level_mode = 1'b0, cfg_clear = 1'b0;
  logic [1:0] cfg_pulse_sel = 2'd0;
  logic       magic_hit = 1'b0, pattern_hit = 1'b0, frame_end = 1'b0, crc_ok = 1'b0;
  logic       wake_out;
  logic [1:0] wake_status;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  localparam int WIN = 80;

  always #5 clk = ~clk;

  wake_ind_gen u_wake_ind_gen (
    .clk(clk), .rst_n(rst_n),
    .cfg_wake_en(cfg_wake_en), .cfg_magic_en(cfg_magic_en),
    .cfg_pattern_en(cfg_pattern_en), .cfg_crc_gate(cfg_crc_gate),
    .cfg_level_mode(cfg_level_mode), .cfg_pulse_sel(cfg_pulse_sel),
    .cfg_clear(cfg_clear), .magic_hit(magic_hit), .pattern_hit(pattern_hit),
    .frame_end(frame_end), .crc_ok(crc_ok),
    .wake_out(wake_out), .wake_status(wake_status)
  );

  typedef struct packed {
    logic [3:0] req;
    logic [1:0] sel;
    logic       lvl, gate, en, men, pen, m, p, crc;
    logic [7:0] width;
    logic [1:0] stat;
  } vec_t;

  // the expected width is 8 << sel, or the whole window in level mode
  localparam vec_t VECS [12] = '{
    '{4'd2,  2'd0, 1'b0,1'b1,1'b1,1'b1,1'b1, 1'b1,1'b0,1'b1, 8'd8,  2'b01}, // R2 R7
    '{4'd2,  2'd1, 1'b0,1'b1,1'b1,1'b1,1'b1, 1'b0,1'b1,1'b1, 8'd16, 2'b10}, // R2
    '{4'd2,  2'd2, 1'b0,1'b1,1'b1,1'b1,1'b1, 1'b1,1'b1,1'b1, 8'd32, 2'b11}, // R2
    '{4'd2,  2'd3, 1'b0,1'b1,1'b1,1'b1,1'b1, 1'b1,1'b0,1'b1, 8'd64, 2'b01}, // R2
    '{4'd4,  2'd0, 1'b0,1'b1,1'b1,1'b1,1'b1, 1'b1,1'b0,1'b0, 8'd0,  2'b00}, // R4 bad CRC
    '{4'd8,  2'd0, 1'b0,1'b1,1'b1,1'b1,1'b1, 1'b0,1'b0,1'b1, 8'd0,  2'b00}, // R8 empty frame, R4 discard
    '{4'd5,  2'd0, 1'b0,1'b0,1'b1,1'b1,1'b1, 1'b1,1'b0,1'b0, 8'd8,  2'b01}, // R5 gate off
    '{4'd6,  2'd0, 1'b0,1'b1,1'b0,1'b1,1'b1, 1'b1,1'b1,1'b1, 8'd0,  2'b00}, // R6 master off
    '{4'd7,  2'd0, 1'b0,1'b1,1'b1,1'b0,1'b1, 1'b1,1'b0,1'b1, 8'd0,  2'b00}, // R7 magic disabled
    '{4'd7,  2'd0, 1'b0,1'b1,1'b1,1'b0,1'b1, 1'b1,1'b1,1'b1, 8'd8,  2'b10}, // R7 only pattern
    '{4'd3,  2'd0, 1'b1,1'b1,1'b1,1'b1,1'b1, 1'b1,1'b0,1'b1, 8'd80, 2'b01}, // R3 level held
    '{4'd4,  2'd0, 1'b1,1'b1,1'b1,1'b1,1'b1, 1'b0,1'b1,1'b0, 8'd0,  2'b00}  // R4 level, bad CRC
  };

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // hits one cycle, frame_end next; returns at the negedge after the firing edge
  task automatic send_frame(input logic m, input logic p, input logic crc);
    @(negedge clk); magic_hit = m; pattern_hit = p;
    @(negedge clk); magic_hit = 1'b0; pattern_hit = 1'b0; frame_end = 1'b1; crc_ok = crc;
    @(negedge clk); frame_end = 1'b0; crc_ok = 1'b0;
  endtask

  task automatic count_high(output int n);
    n = 0;
    for (int i = 0; i < WIN; i++) begin
      if (wake_out) n++;
      @(negedge clk);
    end
  endtask

  task automatic strobe_clear();
    cfg_clear = 1'b1;
    @(negedge clk); cfg_clear = 1'b0;
  endtask

  initial begin
    repeat (2000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int n;
    string tag;
    #1;
    check("R1 reset wake_out", int'(wake_out), 0);
    check("R1 reset status", int'(wake_status), 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after release wake_out", int'(wake_out), 0);
    check("R1 after release status", int'(wake_status), 0);

    foreach (VECS[k]) begin
      tag = $sformatf("R%0d row%0d", VECS[k].req, k);
      @(negedge clk);
      cfg_pulse_sel = VECS[k].sel; cfg_level_mode = VECS[k].lvl;
      cfg_crc_gate = VECS[k].gate; cfg_wake_en = VECS[k].en;
      cfg_magic_en = VECS[k].men; cfg_pattern_en = VECS[k].pen;
      send_frame(VECS[k].m, VECS[k].p, VECS[k].crc);
      count_high(n);
      check({tag, " width"}, n, int'(VECS[k].width));
      check({tag, " status"}, int'(wake_status), int'(VECS[k].stat));
      strobe_clear();
      check({tag, " after clear out"}, int'(wake_out), 0);
      check({tag, " after clear status"}, int'(wake_status), 0);
    end

    // R8: hit in the same cycle as frame_end
    cfg_level_mode = 1'b0; cfg_crc_gate = 1'b1; cfg_wake_en = 1'b1;
    cfg_magic_en = 1'b1; cfg_pattern_en = 1'b1; cfg_pulse_sel = 2'd0;
    @(negedge clk); magic_hit = 1'b1; frame_end = 1'b1; crc_ok = 1'b1;
    @(negedge clk); magic_hit = 1'b0; frame_end = 1'b0; crc_ok = 1'b0;
    count_high(n);
    check("R8 same-cycle hit width", n, 8);
    check("R8 same-cycle hit status", int'(wake_status), 1);
    strobe_clear();

    // R9: second event during a pulse reloads the full width
    send_frame(1'b1, 1'b0, 1'b1);
    @(negedge clk);
    send_frame(1'b0, 1'b1, 1'b1);
    count_high(n);
    check("R9 remaining width after restart", n, 8);
    check("R9 status both sources", int'(wake_status), 3);
    strobe_clear();

    // R10: clear and a firing event in the same cycle, level mode
    cfg_level_mode = 1'b1;
    send_frame(1'b1, 1'b0, 1'b1);
    check("R3 level raised", int'(wake_out), 1);
    check("R10 status magic", int'(wake_status), 1);
    pattern_hit = 1'b1;
    @(negedge clk); pattern_hit = 1'b0; frame_end = 1'b1; crc_ok = 1'b1; cfg_clear = 1'b1;
    @(negedge clk); frame_end = 1'b0; crc_ok = 1'b0; cfg_clear = 1'b0;
    check("R10 level kept on collision", int'(wake_out), 1);
    check("R10 status only new source", int'(wake_status), 2);
    strobe_clear();
    check("R3 level cleared", int'(wake_out), 0);

    done = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule